// File: doc/BRIEF.md
# Serial Management Frame Responder

This block is the target side of a two-wire serial management bus: a clock line (MDC) and a bidirectional data line (MDIO). The bus master may be a hardware controller or software toggling pins. The lines are oversampled by the system clock. The block follows each frame field by field: the preamble, the two start bits, a 2-bit operation code, a 5-bit device address and a 5-bit register number. A two-cycle turnaround comes next, and then a 16-bit data word.

A read addressed to this block's configured device address raises a one-clock request on a register port. The returned word is then shifted onto the data line under an output enable. A write collects sixteen bits and hands the complete word to the register port in one pulse after the last bit. The register port suits a block RAM or a register file with one clock of read latency. The device address is an input, so the same block can sit at any address on the bus.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: During and after synchronous reset, `mdio_oe`, `mdio_out`, `rp_rd_en` and `rp_wr_en` are low and the frame decoder waits for a preamble.
- R2: A frame begins only after at least 32 consecutive MDC rising edges that sample MDIO high, followed by a rising edge that samples MDIO low (first start bit). A run of 31 ones followed by a low bit starts nothing.
- R3: The MDC cycle after the first start bit must sample MDIO high; otherwise the frame is dropped and a new preamble is required.
- R4: The operation code (2 bits), device address (5 bits) and register number (5 bits) are taken MSB first on rising MDC. Two turnaround cycles follow, whose line values are ignored.
- R5: Operation code 2'b10 (read) at a device address equal to `own_phy_addr` produces exactly one `rp_rd_en` pulse on the second turnaround rising edge, with `rp_reg_addr` holding the register number. `rp_rdata` is taken one clock after the pulse.
- R6: Read data is presented MSB first, one bit per MDC cycle, with `mdio_out` changing only after falling MDC edges, for 16 bits.
- R7: A read whose device address differs from `own_phy_addr` returns 16'hFFFF on the line and raises no `rp_rd_en`.
- R8: Operation code 2'b01 (write) samples 16 data bits MSB first on rising MDC. After the sixteenth bit it gives one `rp_wr_en` pulse with the register number and full word, provided the device address matches. A mismatched address gives no pulse.
- R9: Operation codes 2'b00 and 2'b11 consume a frame without any register-port access and without driving the line.
- R10: `mdio_oe` is high only during the data phase of a read, from the end of turnaround to the sixteenth data rising edge, and never in any other frame.
- R11: After each frame the decoder returns to the preamble wait, so a frame sent with no preamble directly after another is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| own_phy_addr | input | 5 | Device address this block answers to |
| mdc_in | input | 1 | Management clock from the bus |
| mdio_in | input | 1 | Management data line as seen at the pad |
| mdio_out | output | 1 | Data driven onto the line during a read |
| mdio_oe | output | 1 | Output enable for the data line driver |
| rp_rd_en | output | 1 | One-clock register read request |
| rp_wr_en | output | 1 | One-clock register write request |
| rp_reg_addr | output | 5 | Register number for the request |
| rp_wdata | output | 16 | Write data for the request |
| rp_rdata | input | 16 | Read data, valid one clock after `rp_rd_en` |

## Verification
On every clock, the embedded assertions check several properties. Register-port requests are single-clock pulses, and a read and a write never coincide. The output enable can only rise straight out of turnaround. The data output moves only right after an MDC edge, and the decoder leaves the preamble only for the start state. The bench scenarios have to show the rest: the serial word a master sees on a read, the word delivered on a write, address filtering with the 16'hFFFF answer, and the exact 31-versus-32 preamble boundary. They also cover the rejection of a bad start bit, of unused operation codes and of a frame sent without a preamble.

// File: rtl/mgs_pkg.sv
package mgs_pkg;
  typedef enum logic [2:0] {
    S_PRE  = 3'd0,
    S_ST   = 3'd1,
    S_OP   = 3'd2,
    S_PHY  = 3'd3,
    S_REG  = 3'd4,
    S_TA   = 3'd5,
    S_DAT  = 3'd6
  } frm_state_t;

  localparam logic [1:0] OPC_RD = 2'b10;
  localparam logic [1:0] OPC_WR = 2'b01;
endpackage

// File: rtl/mgs_sync.sv
module mgs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mgs_frame.sv
module mgs_frame
  import mgs_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rise,
  input  logic              fall,
  input  logic              sd,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              rd_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rdata
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [PRE_W-1:0] PRE_MAX  = PRE_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_TWO = CNT_W'(1);

  frm_state_t        state;
  logic [PRE_W-1:0]  pre_cnt;
  logic [CNT_W-1:0]  bcnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] phy_q;
  logic [DATA_W-1:0] sh;
  logic              hit;
  logic              fetch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_PRE;
      pre_cnt  <= '0;
      bcnt     <= '0;
      opc      <= '0;
      phy_q    <= '0;
      reg_addr <= '0;
      sh       <= '0;
      hit      <= 1'b0;
      fetch    <= 1'b0;
      rd_en    <= 1'b0;
      wr_en    <= 1'b0;
      wdata    <= '0;
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end else begin
      rd_en <= 1'b0;
      wr_en <= 1'b0;
      fetch <= rd_en;
      if (fetch) sh <= rdata;
      if (rise) begin
        case (state)
          S_PRE: begin
            if (sd) begin
              if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PRE_MAX) state <= S_ST;
              pre_cnt <= '0;
            end
          end
          S_ST: begin
            bcnt  <= '0;
            state <= sd ? S_OP : S_PRE;
          end
          S_OP: begin
            opc <= {opc[0], sd};
            if (bcnt == LAST_TWO) begin bcnt <= '0; state <= S_PHY; end
            else bcnt <= bcnt + 1'b1;
          end
          S_PHY: begin
            phy_q <= {phy_q[ADDR_W-2:0], sd};
            if (bcnt == LAST_ADR) begin bcnt <= '0; state <= S_REG; end
            else bcnt <= bcnt + 1'b1;
          end
          S_REG: begin
            reg_addr <= {reg_addr[ADDR_W-2:0], sd};
            if (bcnt == LAST_ADR) begin bcnt <= '0; state <= S_TA; end
            else bcnt <= bcnt + 1'b1;
          end
          S_TA: begin
            if (bcnt == LAST_TWO) begin
              bcnt     <= '0;
              state    <= S_DAT;
              mdio_out <= 1'b0;
              hit      <= (phy_q == own_addr);
              if (opc == OPC_RD) begin
                mdio_oe <= 1'b1;
                if (phy_q == own_addr) rd_en <= 1'b1;
                else                   sh    <= '1;
              end
            end else bcnt <= bcnt + 1'b1;
          end
          S_DAT: begin
            if (opc != OPC_RD) sh <= {sh[DATA_W-2:0], sd};
            if (bcnt == LAST_DAT) begin
              bcnt    <= '0;
              state   <= S_PRE;
              mdio_oe <= 1'b0;
              if (opc == OPC_WR && hit) begin
                wr_en <= 1'b1;
                wdata <= {sh[DATA_W-2:0], sd};
              end
            end else bcnt <= bcnt + 1'b1;
          end
          default: state <= S_PRE;
        endcase
      end else if (fall && state == S_DAT && mdio_oe) begin
        mdio_out <= sh[DATA_W-1];
        sh       <= {sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);
  assert_wr_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  assert_no_both_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));
  assert_oe_from_ta_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> $past(state) == S_TA);
  assert_out_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_out) |-> ($past(fall) || $past(rise)));
  assert_pre_exit_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_PRE && state != S_PRE) |-> state == S_ST);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int PRE_LEN   = 32,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_phy_addr,
  input  logic              mdc_in,
  input  logic              mdio_in,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              rp_rd_en,
  output logic              rp_wr_en,
  output logic [ADDR_W-1:0] rp_reg_addr,
  output logic [DATA_W-1:0] rp_wdata,
  input  logic [DATA_W-1:0] rp_rdata
);
  logic [1:0] sync_q;
  logic       mdc_d;
  logic       mdc_rise;
  logic       mdc_fall;

  mgs_sync #(.WIDTH(2), .STAGES(SYNC_STGS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mdc_in, mdio_in}),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) mdc_d <= 1'b0;
    else     mdc_d <= sync_q[1];
  end

  assign mdc_rise = sync_q[1] & ~mdc_d;
  assign mdc_fall = ~sync_q[1] & mdc_d;

  mgs_frame #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .own_addr (own_phy_addr),
    .rise     (mdc_rise),
    .fall     (mdc_fall),
    .sd       (sync_q[0]),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rd_en    (rp_rd_en),
    .wr_en    (rp_wr_en),
    .reg_addr (rp_reg_addr),
    .wdata    (rp_wdata),
    .rdata    (rp_rdata)
  );
endmodule

// File: tb/mdio_mgmt_slave_bench.sv
module mdio_mgmt_slave_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  own = 5'd1;
  logic        mdc_in = 1'b0;
  logic        mdio_in = 1'b1;
  logic        mdio_out, mdio_oe, rp_rd_en, rp_wr_en;
  logic [4:0]  rp_reg_addr;
  logic [15:0] rp_wdata;
  logic [15:0] rp_rdata = 16'h0;
  logic [15:0] mem [32];

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, oe_viol = 0;
  logic [4:0]  last_rd_reg = '0, last_wr_reg = '0;
  logic [15:0] last_wdata = '0;
  logic        win = 1'b0;
  logic [15:0] rv;
  logic        oe_seen;

  always #2 clk = ~clk;

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .clk(clk), .rst(rst), .own_phy_addr(own), .mdc_in(mdc_in), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rp_rd_en(rp_rd_en), .rp_wr_en(rp_wr_en),
    .rp_reg_addr(rp_reg_addr), .rp_wdata(rp_wdata), .rp_rdata(rp_rdata)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  // register-file model with one clock of read latency
  always @(posedge clk) begin
    if (rp_rd_en) begin
      rp_rdata <= mem[rp_reg_addr];
      rd_cnt++;
      last_rd_reg <= rp_reg_addr;
    end
    if (rp_wr_en) begin
      mem[rp_reg_addr] <= rp_wdata;
      wr_cnt++;
      last_wr_reg <= rp_reg_addr;
      last_wdata  <= rp_wdata;
    end
  end

  // R10 per-clock comparison against the model's drive window
  always @(negedge clk) begin
    if (!rst && mdio_oe && !win) oe_viol++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(logic b);
    @(negedge clk) mdio_in = b;
    repeat (HALF) @(negedge clk);
    mdc_in = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc_in = 1'b0;
  endtask

  task automatic read_bit(output logic b, output logic oe);
    @(negedge clk) mdio_in = 1'b1;
    repeat (HALF) @(negedge clk);
    b  = mdio_out;
    oe = mdio_oe;
    mdc_in = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc_in = 1'b0;
  endtask

  task automatic frame(int npre, logic [1:0] st, logic [1:0] op, logic [4:0] phy,
                       logic [4:0] ra, logic [15:0] wd, bit resp,
                       output logic [15:0] val, output logic oe_all);
    logic b, o;
    for (int i = 0; i < npre; i++) drive_bit(1'b1);
    drive_bit(st[1]); drive_bit(st[0]);
    for (int i = 1; i >= 0; i--) drive_bit(op[i]);
    for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
    for (int i = 4; i >= 0; i--) drive_bit(ra[i]);
    drive_bit(1'b1);
    if (resp) win = 1'b1;
    drive_bit(resp ? 1'b1 : 1'b0);
    val = '0;
    oe_all = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      if (resp) begin
        read_bit(b, o);
        val[i] = b;
        oe_all = oe_all & o;
      end else drive_bit(wd[i]);
    end
    win = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rc, wc;
    for (int i = 0; i < 32; i++) mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
    chk("R1 out", {31'd0, mdio_out}, 32'd0);
    chk("R1 rd_en", {31'd0, rp_rd_en}, 32'd0);
    chk("R1 wr_en", {31'd0, rp_wr_en}, 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R8 write at own address
    frame(32, 2'b01, 2'b01, 5'd1, 5'd4, 16'hA5C3, 0, rv, oe_seen);
    repeat (4) @(negedge clk);
    chk("R8 write count", wr_cnt, 1);
    chk("R4 write reg", {27'd0, last_wr_reg}, 32'd4);
    chk("R8 write data", {16'd0, last_wdata}, 32'hA5C3);

    // R5 R6 R10 read back
    frame(32, 2'b01, 2'b10, 5'd1, 5'd4, 16'h0, 1, rv, oe_seen);
    chk("R5 read count", rd_cnt, 1);
    chk("R5 read reg", {27'd0, last_rd_reg}, 32'd4);
    chk("R6 read data", {16'd0, rv}, 32'hA5C3);
    chk("R10 oe in data", {31'd0, oe_seen}, 32'd1);

    // R4 other register, exactly 32 preamble bits back to back
    frame(32, 2'b01, 2'b10, 5'd1, 5'd17, 16'h0, 1, rv, oe_seen);
    chk("R4 reg17 data", {16'd0, rv}, {16'd0, init_val(17)});

    // R7 foreign address read
    rc = rd_cnt;
    frame(32, 2'b01, 2'b10, 5'd3, 5'd4, 16'h0, 1, rv, oe_seen);
    chk("R7 foreign data", {16'd0, rv}, 32'hFFFF);
    chk("R7 no rd_en", rd_cnt, rc);

    // R8 foreign address write is dropped
    wc = wr_cnt;
    frame(32, 2'b01, 2'b01, 5'd3, 5'd4, 16'h1234, 0, rv, oe_seen);
    repeat (4) @(negedge clk);
    chk("R8 foreign write", wr_cnt, wc);
    frame(32, 2'b01, 2'b10, 5'd1, 5'd4, 16'h0, 1, rv, oe_seen);
    chk("R8 reg kept", {16'd0, rv}, 32'hA5C3);

    // R2 31-bit preamble starts nothing
    rc = rd_cnt;
    frame(31, 2'b01, 2'b10, 5'd1, 5'd4, 16'h0, 0, rv, oe_seen);
    chk("R2 short preamble", rd_cnt, rc);

    // R3 bad second start bit
    frame(32, 2'b00, 2'b10, 5'd1, 5'd4, 16'h0, 0, rv, oe_seen);
    chk("R3 bad start", rd_cnt, rc);
    frame(32, 2'b01, 2'b10, 5'd1, 5'd2, 16'h0, 1, rv, oe_seen);
    chk("R2 recover read", {16'd0, rv}, {16'd0, init_val(2)});

    // R9 unused opcodes
    rc = rd_cnt; wc = wr_cnt;
    frame(32, 2'b01, 2'b11, 5'd1, 5'd4, 16'hFFFF, 0, rv, oe_seen);
    frame(32, 2'b01, 2'b00, 5'd1, 5'd4, 16'h5555, 0, rv, oe_seen);
    repeat (4) @(negedge clk);
    chk("R9 no read", rd_cnt, rc);
    chk("R9 no write", wr_cnt, wc);

    // R11 frame without preamble right after a frame
    frame(0, 2'b01, 2'b10, 5'd1, 5'd4, 16'h0, 0, rv, oe_seen);
    chk("R11 no preamble", rd_cnt, rc);

    // R5 R7 own address moved
    own = 5'd7;
    frame(32, 2'b01, 2'b10, 5'd7, 5'd9, 16'h0, 1, rv, oe_seen);
    chk("R5 new addr data", {16'd0, rv}, {16'd0, init_val(9)});
    chk("R5 new addr reg", {27'd0, last_rd_reg}, 32'd9);
    frame(32, 2'b01, 2'b10, 5'd1, 5'd9, 16'h0, 1, rv, oe_seen);
    chk("R7 old addr data", {16'd0, rv}, 32'hFFFF);

    repeat (8) @(negedge clk);
    chk("R10 oe outside window", oe_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule